// File: doc/BRIEF.md
# Module Configuration Chain Decoder

This block owns the memory map of a 20-bit nibble-addressed space. The space is cut into 256 pages of 4096 nibbles, and the page number is the top byte of an address. Configuration commands fill a fixed sequence of nine steps, one per command. The first step places a 64-nibble I/O window. The remaining eight are a size step followed by a base step for each of four memory modules: main RAM, a bank-switch region, expansion port 1 and expansion port 2. An identify command reports which step is waiting, so firmware can walk the chain without knowing in advance what is fitted.

Separate commands remove one module or the I/O window again, or clear the whole map. Each access address is decoded by combinational logic. The decode picks exactly one target (I/O window, one of the four modules, or the ROM underneath everything) and gives the nibble offset inside that target. A module image repeats when the module's page range is larger than its capacity.

Top module: `cfg_chain_decoder`

## Requirements
- R1: A command is taken on a clock edge when `cmd_valid` is high. `cmd_op` selects the command: 0 configure, 1 unconfigure, 2 clear map, 3 identify. A configure command completes only the lowest unfinished step. The step order is I/O, RAM size, RAM base, bank size, bank base, port 1 size, port 1 base, port 2 size, port 2 base.
- R2: The I/O step stores `cmd_arg & 0xFFFC0` as the window base. An address whose bits 19..6 match that base selects I/O (`acc_sel`=5), and the offset is the address bits 5..0.
- R3: The page byte p is `cmd_arg[19:12]`. A size step stores ~p. A base step stores p as the base and stores end = base + size, modulo 256. A module covers the pages from base to end inclusive, so an end that wraps below the base covers no page.
- R4: Identify loads `id_data` on the next edge with (value << 12) XOR code. The value is the stored base or size of the waiting step, truncated to 20 bits. The codes are: I/O 0x00019; RAM 0xFF003 for size and 0x000F4 for base; bank 0xFF005 and 0x000F6; port 1 0xFF007 and 0x000F8; port 2 0xFF001 and 0x000F2. When no step is waiting, the result is 0.
- R5: Unconfigure first checks the full 20-bit operand against a placed I/O base, and a match moves the window to 0x100000, which no address reaches. Failing that, it compares p with the base of each placed module in the order RAM, bank, port 1, port 2. Only the first match reopens both of that module's steps. An operand that matches nothing changes nothing.
- R6: The clear-map command and `rst_n` low both reopen every step, zero all bases, sizes and ends, and move the I/O window to 0x100000. `rst_n` low also clears `id_data` to 0.
- R7: Decode priority is I/O, then RAM, then bank, then port 1, then port 2, then ROM. The `acc_sel` codes are ROM 0, RAM 1, bank 2, port 1 3, port 2 4, I/O 5. ROM covers every page and its offset is the full address.
- R8: A module offset is ({page - base, addr[11:0]}) AND (units × 2048 − 1). The units are the capacity parameter of each module in 2K-nibble units.
- R9: `acc_wr_en` follows `acc_write` for RAM and I/O. It follows `acc_write & p1_wr_en` for port 1 and `acc_write & p2_wr_en` for port 2. It is 0 for the bank region and for ROM.
- R10: A configure command given when all nine steps are finished changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_arg | input | 20 | Command operand |
| id_data | output | 20 | Result of the last identify |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | Access is a write |
| p1_wr_en | input | 1 | Port 1 accepts writes |
| p2_wr_en | input | 1 | Port 2 accepts writes |
| acc_sel | output | 3 | Selected target |
| acc_offset | output | 20 | Offset inside the target |
| acc_wr_en | output | 1 | Write reaches the target |

## Verification
A wrong step pointer appears in the very next identify result. The bench checks identify after every configure, so a skipped or repeated step shows up within two cycles. A wrong stored base, size or end does not appear in identify once its step is done. It shows up as a wrong `acc_sel` or `acc_offset` for addresses at the edges of a range, so those edges are probed directly. Errors in the unconfigure order or in clearing the map appear as a changed identify code and as pages that fall back to ROM.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int NMOD  = 4;
    localparam int NSTEP = 1 + 2 * NMOD;

    typedef enum logic [1:0] {
        CMD_CFG   = 2'd0,
        CMD_UNCFG = 2'd1,
        CMD_CLR   = 2'd2,
        CMD_ID    = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        SEL_ROM   = 3'd0,
        SEL_RAM   = 3'd1,
        SEL_BANK  = 3'd2,
        SEL_PORT1 = 3'd3,
        SEL_PORT2 = 3'd4,
        SEL_IO    = 3'd5
    } sel_e;

    localparam logic [20:0] IO_PARKED = 21'h100000;
    localparam logic [19:0] IO_CODE   = 20'h00019;

    function automatic logic [19:0] size_code(input int m);
        case (m)
            0:       return 20'hFF003;
            1:       return 20'hFF005;
            2:       return 20'hFF007;
            default: return 20'hFF001;
        endcase
    endfunction

    function automatic logic [19:0] base_code(input int m);
        case (m)
            0:       return 20'h000F4;
            1:       return 20'h000F6;
            2:       return 20'h000F8;
            default: return 20'h000F2;
        endcase
    endfunction
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfgdec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [19:0]               cmd_arg,
    output logic [NSTEP-1:0]          done,
    output logic [20:0]               io_base,
    output logic [NMOD-1:0][7:0]      mod_base,
    output logic [NMOD-1:0][7:0]      mod_end,
    output logic [19:0]               id_data
);
    typedef struct packed {
        logic [NSTEP-1:0]     done;
        logic [20:0]          io_base;
        logic [NMOD-1:0][7:0] base;
        logic [NMOD-1:0][7:0] size;
        logic [NMOD-1:0][7:0] endp;
        logic [19:0]          id;
    } st_t;

    st_t st_d, st_q;
    logic [3:0] first;
    logic       open;
    logic       hit;
    logic [7:0] pg;
    int         m;

    assign pg = cmd_arg[19:12];

    // lowest unfinished step
    always_comb begin
        first = '0;
        open  = 1'b0;
        for (int i = NSTEP - 1; i >= 0; i--) begin
            if (!st_q.done[i]) begin
                first = 4'(i);
                open  = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        m    = 0;
        if (cmd_valid) begin
            case (cmd_e'(cmd_op))
                CMD_CFG: begin
                    if (open) begin
                        st_d.done[first] = 1'b1;
                        if (first == 4'd0) begin
                            st_d.io_base = {1'b0, cmd_arg[19:6], 6'b0};
                        end else if (first[0]) begin
                            m = (int'(first) - 1) / 2;
                            st_d.size[m] = ~pg;
                        end else begin
                            m = int'(first) / 2 - 1;
                            st_d.base[m] = pg;
                            st_d.endp[m] = pg + st_q.size[m];
                        end
                    end
                end
                CMD_UNCFG: begin
                    if (st_q.done[0] && ({1'b0, cmd_arg} == st_q.io_base)) begin
                        st_d.done[0] = 1'b0;
                        st_d.io_base = IO_PARKED;
                    end else begin
                        for (int k = 0; k < NMOD; k++) begin
                            if (!hit && st_q.done[2*k+2] && (pg == st_q.base[k])) begin
                                st_d.done[2*k+1] = 1'b0;
                                st_d.done[2*k+2] = 1'b0;
                                hit = 1'b1;
                            end
                        end
                    end
                end
                CMD_CLR: begin
                    st_d.done    = '0;
                    st_d.io_base = IO_PARKED;
                    st_d.base    = '0;
                    st_d.size    = '0;
                    st_d.endp    = '0;
                end
                default: begin
                    if (!open) begin
                        st_d.id = '0;
                    end else if (first == 4'd0) begin
                        st_d.id = {st_q.io_base[7:0], 12'h000} ^ IO_CODE;
                    end else if (first[0]) begin
                        m = (int'(first) - 1) / 2;
                        st_d.id = {st_q.size[m], 12'h000} ^ size_code(m);
                    end else begin
                        m = int'(first) / 2 - 1;
                        st_d.id = {st_q.base[m], 12'h000} ^ base_code(m);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.io_base <= IO_PARKED;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign io_base  = st_q.io_base;
    assign mod_base = st_q.base;
    assign mod_end  = st_q.endp;
    assign id_data  = st_q.id;

    // R1: a configure with an open step finishes exactly one more step
    a_r1_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_CFG && open)
        |=> ($countones(st_q.done) == $past($countones(st_q.done)) + 1));

    // R10: configure on a full chain leaves the chain untouched
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_CFG && !open) |=> $stable(st_q.done));

    // R5: unconfigure never finishes a step
    a_r5_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_UNCFG)
        |=> ($countones(st_q.done) <= $past($countones(st_q.done))));

    // R6: clearing the map reopens all steps and parks the window
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_CLR)
        |=> (st_q.done == '0 && st_q.io_base == IO_PARKED));
endmodule

// File: rtl/win_decode.sv
module win_decode #(
    parameter int UNITS = 32
) (
    input  logic        active,
    input  logic [7:0]  base,
    input  logic [7:0]  endp,
    input  logic [19:0] addr,
    output logic        hit,
    output logic [19:0] offset
);
    localparam logic [19:0] MASK = 20'(UNITS * 2048 - 1);

    logic [7:0] rel;

    assign rel    = addr[19:12] - base;
    assign hit    = active && (addr[19:12] >= base) && (addr[19:12] <= endp);
    assign offset = {rel, addr[11:0]} & MASK;
endmodule

// File: rtl/cfg_chain_decoder.sv
module cfg_chain_decoder
    import cfgdec_pkg::*;
#(
    parameter int RAM_UNITS  = 64,
    parameter int BANK_UNITS = 128,
    parameter int P1_UNITS   = 32,
    parameter int P2_UNITS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [19:0] cmd_arg,
    output logic [19:0] id_data,
    input  logic [19:0] acc_addr,
    input  logic        acc_write,
    input  logic        p1_wr_en,
    input  logic        p2_wr_en,
    output logic [2:0]  acc_sel,
    output logic [19:0] acc_offset,
    output logic        acc_wr_en
);
    logic [NSTEP-1:0]       done;
    logic [20:0]            io_base;
    logic [NMOD-1:0][7:0]   mod_base;
    logic [NMOD-1:0][7:0]   mod_end;
    logic [NMOD-1:0]        mod_hit;
    logic [NMOD-1:0][19:0]  mod_off;
    logic                   io_hit;

    cfg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_arg  (cmd_arg),
        .done     (done),
        .io_base  (io_base),
        .mod_base (mod_base),
        .mod_end  (mod_end),
        .id_data  (id_data)
    );

    for (genvar g = 0; g < NMOD; g++) begin : g_win
        localparam int UNITS = (g == 0) ? RAM_UNITS :
                               (g == 1) ? BANK_UNITS :
                               (g == 2) ? P1_UNITS : P2_UNITS;
        win_decode #(.UNITS(UNITS)) u_win (
            .active(done[2*g+2]),
            .base  (mod_base[g]),
            .endp  (mod_end[g]),
            .addr  (acc_addr),
            .hit   (mod_hit[g]),
            .offset(mod_off[g])
        );
    end

    assign io_hit = ({1'b0, acc_addr[19:6], 6'b0} == io_base);

    always_comb begin
        acc_sel    = SEL_ROM;
        acc_offset = acc_addr;
        acc_wr_en  = 1'b0;
        if (io_hit) begin
            acc_sel    = SEL_IO;
            acc_offset = {14'b0, acc_addr[5:0]};
            acc_wr_en  = acc_write;
        end else begin
            for (int k = NMOD - 1; k >= 0; k--) begin
                if (mod_hit[k]) begin
                    acc_sel    = 3'(k + 1);
                    acc_offset = mod_off[k];
                    case (k)
                        0:       acc_wr_en = acc_write;
                        2:       acc_wr_en = acc_write & p1_wr_en;
                        3:       acc_wr_en = acc_write & p2_wr_en;
                        default: acc_wr_en = 1'b0;
                    endcase
                end
            end
        end
    end

    // R2: the I/O target is only chosen inside the placed window
    a_r2_io_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_IO) |-> (acc_addr[19:6] == io_base[19:6] && !io_base[20]));

    // R7: RAM always wins over the other modules on its pages
    a_r7_ram_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_hit[0] && !io_hit) |-> (acc_sel == SEL_RAM));

    // R9: writes never reach ROM or the bank region
    a_r9_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_ROM || acc_sel == SEL_BANK) |-> !acc_wr_en);

    // R8: a port 2 offset stays inside its capacity
    a_r8_p2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_PORT2) |-> (acc_offset < 20'(P2_UNITS * 2048)));
endmodule

// File: tb/cfg_chain_decoder_tb.sv
module cfg_chain_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_CFG = 2'd0, OP_UNC = 2'd1, OP_CLR = 2'd2, OP_ID = 2'd3;

    // {op, operand, identify result expected afterwards}
    localparam logic [41:0] VEC [10] = '{
        {OP_CFG, 20'h20040, 20'hFF003},
        {OP_CFG, 20'hFC000, 20'h000F4},
        {OP_CFG, 20'h80000, 20'hFF005},
        {OP_CFG, 20'hFF000, 20'h000F6},
        {OP_CFG, 20'h80000, 20'hFF007},
        {OP_CFG, 20'hFE000, 20'h000F8},
        {OP_CFG, 20'h40000, 20'hFF001},
        {OP_CFG, 20'hF0000, 20'h000F2},
        {OP_CFG, 20'h40000, 20'h00000},
        {OP_CFG, 20'h12345, 20'h00000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [19:0] cmd_arg = '0;
    logic [19:0] id_data;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        p1_wr_en = 1'b0;
    logic        p2_wr_en = 1'b0;
    logic [2:0]  acc_sel;
    logic [19:0] acc_offset;
    logic        acc_wr_en;
    int          checks = 0;
    int          errors = 0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_chain_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .id_data(id_data), .acc_addr(acc_addr),
        .acc_write(acc_write), .p1_wr_en(p1_wr_en), .p2_wr_en(p2_wr_en),
        .acc_sel(acc_sel), .acc_offset(acc_offset), .acc_wr_en(acc_wr_en)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [19:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ident(input string tag, input logic [19:0] exp);
        cmd(OP_ID, 20'h0);
        chk(tag, id_data, exp);
    endtask

    task automatic dec(input string tag, input logic [19:0] a, input logic w,
                       input logic [2:0] es, input logic [19:0] eo, input logic ew);
        acc_addr = a; acc_write = w;
        #1;
        chk({tag, " sel"}, 20'(acc_sel), 20'(es));
        chk({tag, " offset"}, acc_offset, eo);
        chk({tag, " wr"}, 20'(acc_wr_en), 20'(ew));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        chk("R6 reset id", id_data, 20'h0);
        dec("R6 reset map", 20'h00000, 1'b1, 3'd0, 20'h00000, 1'b0);
        ident("R4 first step io", 20'h00019);

        // R1 R3 R4 R10 chain walk
        for (int i = 0; i < 10; i++) begin
            cmd(VEC[i][41:40], VEC[i][39:20]);
            ident($sformatf("R1 R4 R10 chain row %0d", i), VEC[i][19:0]);
        end

        // R2 window
        dec("R2 io inside", 20'h20045, 1'b1, 3'd5, 20'h00005, 1'b1);
        dec("R2 io top", 20'h2007F, 1'b0, 3'd5, 20'h0003F, 1'b0);
        dec("R7 rom past io", 20'h20080, 1'b1, 3'd0, 20'h20080, 1'b0);
        // R7 R3 R8 priority and ranges
        dec("R7 ram over bank", 20'h81234, 1'b1, 3'd1, 20'h01234, 1'b1);
        dec("R3 ram end page", 20'h83FFF, 1'b0, 3'd1, 20'h03FFF, 1'b0);
        dec("R3 past ram end", 20'h84000, 1'b0, 3'd0, 20'h84000, 1'b0);
        p1_wr_en = 1'b0; p2_wr_en = 1'b1;
        dec("R9 p1 locked", 20'h41005, 1'b1, 3'd3, 20'h01005, 1'b0);
        p1_wr_en = 1'b1;
        dec("R9 p1 open", 20'h41005, 1'b1, 3'd3, 20'h01005, 1'b1);
        dec("R8 p2 wrap", 20'h42010, 1'b1, 3'd4, 20'h00010, 1'b1);
        dec("R8 p2 top", 20'h4F7AB, 1'b0, 3'd4, 20'h017AB, 1'b0);
        p2_wr_en = 1'b0;
        dec("R9 p2 locked", 20'h4F7AB, 1'b1, 3'd4, 20'h017AB, 1'b0);

        // R5 unconfigure
        cmd(OP_UNC, 20'h55000);
        ident("R5 no match", 20'h00000);
        dec("R5 no match map", 20'h41005, 1'b0, 3'd3, 20'h01005, 1'b0);
        cmd(OP_UNC, 20'h80000);
        ident("R5 ram reopened", 20'hFC003);
        dec("R5 bank uncovered", 20'h80010, 1'b1, 3'd2, 20'h00010, 1'b0);
        dec("R5 ram page gone", 20'h81234, 1'b0, 3'd0, 20'h81234, 1'b0);
        cmd(OP_UNC, 20'h20040);
        ident("R5 io reopened", 20'h00019);
        dec("R5 io gone", 20'h20045, 1'b0, 3'd0, 20'h20045, 1'b0);

        // R6 clear map command
        cmd(OP_CLR, 20'h0);
        ident("R6 clear id", 20'h00019);
        dec("R6 clear map", 20'h41005, 1'b1, 3'd0, 20'h41005, 1'b0);

        // R3 end wraps: base 0xFF size 3 covers nothing
        cmd(OP_CFG, 20'h10000);
        cmd(OP_CFG, 20'hFC000);
        cmd(OP_CFG, 20'hFF000);
        ident("R3 after wrap base", 20'hFF005);
        dec("R3 wrapped end", 20'hFF100, 1'b0, 3'd0, 20'hFF100, 1'b0);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule